// File: doc/BRIEF.md
# Top Interrupt Priority Encoder

This block picks, out of 64 interrupt causes, the one that machine level should handle next. A cause is a candidate when it is pending, enabled and not handed down to a lower privilege level. Each cause has its own priority number, and a flag says whether the priority storage exists at all. The winner is packed into a 32-bit read word that holds its identity and an encoded priority. Software reads this word to find the next interrupt without scanning the pending vector itself.

The selection is a pure function of the current inputs, so reading the word never changes interrupt state. The block has no global interrupt-enable gating, which stays with the trap logic. The word passes through one register on its way to the read data bus. Candidates are ranked first by priority number, where a smaller non-zero number is more urgent, and then by a fixed default order. A priority of zero does not count as "most urgent". Where such a cause ranks, and what it reports, depends on whether its default position comes before or after the machine external interrupt, cause 11.

Top module: `tip_top`

## Requirements
- R1: In the read word, bits 27:16 carry the winning cause number, bits 7:0 carry the encoded priority, and bits 31:28 and 15:8 are always zero.
- R2: When no cause in 1..63 has pending=1, enable=1 and delegate=0, the whole word is zero. Cause 0 is never reported.
- R3: A cause whose delegate bit is 1, or whose pending or enable bit is 0, is never reported, whatever its priority.
- R4: Among candidates with non-zero priority, the smallest priority number wins.
- R5: Equal priorities are settled by a fixed default order, earliest first: causes 63 down to 48, then 11, 3, 7, 9, 1, 5, then the remaining causes 0..47 in ascending order.
- R6: A priority-0 cause that comes before cause 11 in the default order (causes 48..63) beats every non-zero priority and reports encoded priority 0.
- R7: A priority-0 cause at or after cause 11 in the default order loses to every non-zero priority and reports encoded priority 255.
- R8: When the priority-storage flag is 0, the priority inputs are ignored, the winner follows the default order alone, and a non-zero word reports encoded priority 1.
- R9: With a priority width above 8 bits, ranking uses the full value, and a winning priority above 255 reports 255.
- R10: The word is registered. It reflects the inputs sampled at the previous rising clock edge and is zero while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_CAUSE | Pending bit per cause |
| enab_i | input | N_CAUSE | Machine-level enable bit per cause |
| deleg_i | input | N_CAUSE | Delegated-to-lower-privilege bit per cause |
| prio_i | input | N_CAUSE*PRIO_W | Priority number per cause; cause c at bits c*PRIO_W upward |
| prio_impl_i | input | 1 | 1 when the priority storage exists |
| top_o | output | 32 | Registered read word: identity and encoded priority |

## Verification
The assertions assume that N_CAUSE fits the 12-bit identity field and that HI_BASE is above 11, so causes 48..63 are the only ones placed ahead of cause 11. The stimulus keeps to the default configuration, plus one wider-priority copy, to meet this. They also assume that the inputs are steady around each rising edge. The bench guarantees this by changing every input on the falling edge and sampling the word on the following falling edge. The random sweeps bias priorities toward zero and a few small values, so that ties and the zero-priority rules occur often.

// File: rtl/tip_pkg.sv
package tip_pkg;

    localparam int unsigned ID_W      = 12;
    localparam int unsigned EPRIO_W   = 8;
    localparam int unsigned MEI_CAUSE = 11;

    // Rank class: smaller class is more urgent.
    localparam logic [1:0] CLS_ZERO_HI = 2'd0;
    localparam logic [1:0] CLS_NONZERO = 2'd1;
    localparam logic [1:0] CLS_ZERO_LO = 2'd2;

    typedef struct packed {
        logic [3:0]         rsv_hi;
        logic [ID_W-1:0]    iid;
        logic [7:0]         rsv_mid;
        logic [EPRIO_W-1:0] eprio;
    } tip_word_t;

    // Position of a cause in the default order (0 = first).
    function automatic int unsigned dflt_pos(input int unsigned c,
                                             input int unsigned n,
                                             input int unsigned hi_base);
        int unsigned base;
        int unsigned taken;
        base = n - hi_base;
        if (c >= hi_base) return n - 1 - c;
        case (c)
            11: return base;
            3:  return base + 1;
            7:  return base + 2;
            9:  return base + 3;
            1:  return base + 4;
            5:  return base + 5;
            default: begin
                taken = 0;
                if (c > 1)  taken++;
                if (c > 3)  taken++;
                if (c > 5)  taken++;
                if (c > 7)  taken++;
                if (c > 9)  taken++;
                if (c > 11) taken++;
                return base + 6 + c - taken;
            end
        endcase
    endfunction

endpackage

// File: rtl/tip_key_gen.sv
module tip_key_gen
    import tip_pkg::*;
#(
    parameter int unsigned N_CAUSE = 64,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned HI_BASE = 48,
    localparam int unsigned POS_W  = $clog2(N_CAUSE),
    localparam int unsigned KEY_W  = 2 + PRIO_W + POS_W
) (
    input  logic [N_CAUSE-1:0]        elig_i,
    input  logic [N_CAUSE*PRIO_W-1:0] prio_i,
    input  logic                      prio_impl_i,
    output logic [N_CAUSE-1:0]        valid_o,
    output logic [N_CAUSE*KEY_W-1:0]  key_o
);

    localparam int unsigned MEI_POS = dflt_pos(MEI_CAUSE, N_CAUSE, HI_BASE);

    for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
        localparam int unsigned POS_I = dflt_pos(c, N_CAUSE, HI_BASE);
        localparam logic [POS_W-1:0] POS = POS_W'(POS_I);
        localparam logic [1:0] ZCLS = (POS_I < MEI_POS) ? CLS_ZERO_HI : CLS_ZERO_LO;

        logic [PRIO_W-1:0] prio_eff;
        logic [1:0]        cls;

        always_comb begin
            prio_eff = prio_impl_i ? prio_i[c*PRIO_W +: PRIO_W] : '0;
            cls      = (prio_eff != '0) ? CLS_NONZERO : ZCLS;
        end

        assign key_o[c*KEY_W +: KEY_W] = {cls, prio_eff, POS};

        if (c == 0) begin : g_none
            assign valid_o[c] = 1'b0;
        end else begin : g_real
            assign valid_o[c] = elig_i[c];
        end
    end

endmodule

// File: rtl/tip_min_tree.sv
module tip_min_tree #(
    parameter int unsigned N_LEAF = 64,
    parameter int unsigned KEY_W  = 16,
    parameter int unsigned RANK_W = 10,
    localparam int unsigned IDX_W = $clog2(N_LEAF)
) (
    input  logic [N_LEAF-1:0]       valid_i,
    input  logic [N_LEAF*KEY_W-1:0] key_i,
    output logic                    win_valid_o,
    output logic [RANK_W-1:0]       win_rank_o,
    output logic [IDX_W-1:0]        win_idx_o
);

    // Heap layout: node k combines 2k and 2k+1; leaves at N_LEAF..2*N_LEAF-1.
    logic             nv [1:2*N_LEAF-1];
    logic [KEY_W-1:0] nk [1:2*N_LEAF-1];
    logic [IDX_W-1:0] ni [1:2*N_LEAF-1];

    for (genvar i = 0; i < N_LEAF; i++) begin : g_leaf
        assign nv[N_LEAF+i] = valid_i[i];
        assign nk[N_LEAF+i] = key_i[i*KEY_W +: KEY_W];
        assign ni[N_LEAF+i] = IDX_W'(i);
    end

    for (genvar k = 1; k < N_LEAF; k++) begin : g_node
        logic pick_r;
        assign pick_r = nv[2*k+1] && (!nv[2*k] || (nk[2*k+1] < nk[2*k]));
        assign nv[k]  = nv[2*k] | nv[2*k+1];
        assign nk[k]  = pick_r ? nk[2*k+1] : nk[2*k];
        assign ni[k]  = pick_r ? ni[2*k+1] : ni[2*k];
    end

    assign win_valid_o = nv[1];
    assign win_rank_o  = nk[1][KEY_W-1 -: RANK_W];
    assign win_idx_o   = ni[1];

endmodule

// File: rtl/tip_prio_enc.sv
module tip_prio_enc
    import tip_pkg::*;
#(
    parameter int unsigned PRIO_W = 8
) (
    input  logic [1:0]         cls_i,
    input  logic [PRIO_W-1:0]  prio_i,
    input  logic               prio_impl_i,
    output logic [EPRIO_W-1:0] eprio_o
);

    logic [EPRIO_W-1:0] clamped;

    if (PRIO_W > EPRIO_W) begin : g_wide
        assign clamped = (|prio_i[PRIO_W-1:EPRIO_W]) ? '1 : prio_i[EPRIO_W-1:0];
    end else if (PRIO_W == EPRIO_W) begin : g_same
        assign clamped = prio_i;
    end else begin : g_narrow
        assign clamped = {{(EPRIO_W-PRIO_W){1'b0}}, prio_i};
    end

    always_comb begin
        if (!prio_impl_i) begin
            eprio_o = EPRIO_W'(1);
        end else begin
            case (cls_i)
                CLS_ZERO_HI: eprio_o = '0;
                CLS_NONZERO: eprio_o = clamped;
                default:     eprio_o = '1;
            endcase
        end
    end

endmodule

// File: rtl/tip_top.sv
module tip_top
    import tip_pkg::*;
#(
    parameter int unsigned N_CAUSE = 64,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned HI_BASE = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_CAUSE-1:0]        pend_i,
    input  logic [N_CAUSE-1:0]        enab_i,
    input  logic [N_CAUSE-1:0]        deleg_i,
    input  logic [N_CAUSE*PRIO_W-1:0] prio_i,
    input  logic                      prio_impl_i,
    output logic [31:0]               top_o
);

    localparam int unsigned POS_W  = $clog2(N_CAUSE);
    localparam int unsigned IDX_W  = $clog2(N_CAUSE);
    localparam int unsigned RANK_W = 2 + PRIO_W;
    localparam int unsigned KEY_W  = RANK_W + POS_W;

    typedef struct packed {
        tip_word_t word;
    } tip_state_t;

    logic [N_CAUSE-1:0]       elig;
    logic [N_CAUSE-1:0]       cand_valid;
    logic [N_CAUSE*KEY_W-1:0] cand_key;
    logic                     win_valid;
    logic [RANK_W-1:0]        win_rank;
    logic [IDX_W-1:0]         win_idx;
    logic [EPRIO_W-1:0]       win_eprio;
    tip_state_t               state_d, state_q;

    assign elig = pend_i & enab_i & ~deleg_i;

    tip_key_gen #(
        .N_CAUSE (N_CAUSE),
        .PRIO_W  (PRIO_W),
        .HI_BASE (HI_BASE)
    ) key_gen_i (
        .elig_i      (elig),
        .prio_i      (prio_i),
        .prio_impl_i (prio_impl_i),
        .valid_o     (cand_valid),
        .key_o       (cand_key)
    );

    tip_min_tree #(
        .N_LEAF (N_CAUSE),
        .KEY_W  (KEY_W),
        .RANK_W (RANK_W)
    ) tree_i (
        .valid_i     (cand_valid),
        .key_i       (cand_key),
        .win_valid_o (win_valid),
        .win_rank_o  (win_rank),
        .win_idx_o   (win_idx)
    );

    tip_prio_enc #(
        .PRIO_W (PRIO_W)
    ) enc_i (
        .cls_i       (win_rank[RANK_W-1 -: 2]),
        .prio_i      (win_rank[PRIO_W-1:0]),
        .prio_impl_i (prio_impl_i),
        .eprio_o     (win_eprio)
    );

    always_comb begin
        state_d = '0;
        if (win_valid) begin
            state_d.word.iid   = ID_W'(win_idx);
            state_d.word.eprio = win_eprio;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign top_o = state_q.word;

endmodule

// File: rtl/tip_checker.sv
module tip_checker
    import tip_pkg::*;
#(
    parameter int unsigned N_CAUSE = 64,
    parameter int unsigned HI_BASE = 48
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_CAUSE-1:0] pend_i,
    input logic [N_CAUSE-1:0] enab_i,
    input logic [N_CAUSE-1:0] deleg_i,
    input logic               prio_impl_i,
    input logic [31:0]        top_o
);

    localparam int unsigned IDX_W = $clog2(N_CAUSE);

    tip_word_t          w;
    logic [N_CAUSE-1:0] elig_now;
    logic [N_CAUSE-1:0] elig_q;

    assign w        = top_o;
    assign elig_now = pend_i & enab_i & ~deleg_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elig_q <= '0;
        else        elig_q <= elig_now;
    end

    assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (w.rsv_hi == '0) && (w.rsv_mid == '0));

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_now[N_CAUSE-1:1] == '0) |=> (top_o == '0));

    assert_busy_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_now[N_CAUSE-1:1] != '0) |=> (w.iid != '0));

    assert_only_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (w.iid != '0) |-> ((w.iid < N_CAUSE) && elig_q[w.iid[IDX_W-1:0]]));

    assert_zero_prio_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((w.iid != '0) && (w.eprio == '0)) |-> (w.iid >= HI_BASE));

    assert_absent_prio_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_impl_i |=> ((top_o == '0) || (w.eprio == 8'd1)));

endmodule

bind tip_top tip_checker #(
    .N_CAUSE (N_CAUSE),
    .HI_BASE (HI_BASE)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_i      (pend_i),
    .enab_i      (enab_i),
    .deleg_i     (deleg_i),
    .prio_impl_i (prio_impl_i),
    .top_o       (top_o)
);

// File: tb/tip_top_tb_top.sv
`timescale 1ns/1ps
module tip_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] pend, enab, deleg;
    logic [64*8-1:0]  prio_a;
    logic [64*10-1:0] prio_b;
    logic        impl;
    logic [31:0] out_a, out_b;

    int pa [64];
    int opos [64];
    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    tip_top #(.N_CAUSE(64), .PRIO_W(8),  .HI_BASE(48)) dut_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
        .prio_i(prio_a), .prio_impl_i(impl), .top_o(out_a));

    tip_top #(.N_CAUSE(64), .PRIO_W(10), .HI_BASE(48)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
        .prio_i(prio_b), .prio_impl_i(impl), .top_o(out_b));

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // Reference: rank by (class, priority, default position).
    function automatic logic [31:0] model(input int pw);
        logic [63:0] el;
        int best, bkey, bcls, bp, p, cls, key, e;
        el = pend & enab & ~deleg;
        best = -1; bkey = 0; bcls = 0; bp = 0;
        for (int c = 1; c < 64; c++) begin
            if (el[c]) begin
                p = impl ? (pa[c] & ((1 << pw) - 1)) : 0;
                cls = (p != 0) ? 1 : ((opos[c] < opos[11]) ? 0 : 2);
                key = cls * 1000000 + p * 100 + opos[c];
                if (best < 0 || key < bkey) begin
                    best = c; bkey = key; bcls = cls; bp = p;
                end
            end
        end
        if (best < 0) return 32'h0;
        if (!impl) e = 1;
        else if (bcls == 0) e = 0;
        else if (bcls == 2) e = 255;
        else e = (bp > 255) ? 255 : bp;
        return (32'(best) << 16) | 32'(e);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pack();
        for (int c = 0; c < 64; c++) begin
            prio_a[c*8 +: 8]   = pa[c][7:0];
            prio_b[c*10 +: 10] = pa[c][9:0];
        end
    endtask

    task automatic step();
        pack();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear();
        pend = '0; enab = '0; deleg = '0; impl = 1'b1;
        for (int c = 0; c < 64; c++) pa[c] = 0;
    endtask

    task automatic put(input int c, input int p);
        pend[c] = 1'b1; enab[c] = 1'b1; pa[c] = p;
    endtask

    task automatic both(input string tag, input logic [31:0] exp);
        step();
        chk({tag, " narrow"}, out_a, exp);
        chk({tag, " wide"},   out_b, exp);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int k;
        k = 0;
        for (int c = 63; c >= 48; c--) begin opos[c] = k; k++; end
        opos[11] = k; k++; opos[3] = k; k++; opos[7] = k; k++;
        opos[9]  = k; k++; opos[1] = k; k++; opos[5] = k; k++;
        for (int c = 0; c < 48; c++) begin
            if (c != 1 && c != 3 && c != 5 && c != 7 && c != 9 && c != 11) begin
                opos[c] = k; k++;
            end
        end

        // R10: reset state with busy inputs
        rst_n = 1'b0;
        clear();
        pend = '1; enab = '1;
        for (int c = 0; c < 64; c++) pa[c] = 3;
        pack();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset narrow", out_a, 32'h0);
        chk("R10 reset wide",   out_b, 32'h0);
        rst_n = 1'b1;

        // R1/R2: single-cause sweep
        for (int c = 0; c < 64; c++) begin
            clear();
            put(c, c + 1);
            both("R1 single cause", (c == 0) ? 32'h0 : ((32'(c) << 16) | 32'(c + 1)));
        end
        clear();
        both("R2 nothing pending", 32'h0);

        // R5: default-order ties
        clear();
        for (int c = 1; c < 64; c++) put(c, 5);
        both("R5 all equal", 32'h003F_0005);
        clear(); put(3, 7); put(11, 7);
        both("R5 11 before 3", 32'h000B_0007);
        clear(); put(3, 7); put(7, 7);
        both("R5 3 before 7", 32'h0003_0007);
        clear(); put(1, 4); put(5, 4); put(2, 4);
        both("R5 1 before 5 and 2", 32'h0001_0004);
        clear(); put(2, 9); put(4, 9);
        both("R5 2 before 4", 32'h0002_0009);
        clear(); put(48, 9); put(63, 9); put(11, 9);
        both("R5 63 first", 32'h003F_0009);

        // R4: smaller non-zero number wins
        clear(); put(20, 9); put(40, 3); put(63, 4);
        both("R4 lowest number", 32'h0028_0003);

        // R6 / R7: priority zero
        clear(); put(50, 0); put(11, 1);
        both("R6 zero high", 32'h0032_0000);
        clear(); put(3, 0); put(20, 200);
        both("R7 zero low loses", 32'h0014_00C8);
        clear(); put(11, 0);
        both("R7 cause 11 zero", 32'h000B_00FF);

        // R3: delegation and enable gating
        clear(); put(5, 2); put(9, 6); deleg[5] = 1'b1;
        both("R3 delegated skipped", 32'h0009_0006);
        clear(); put(5, 2); deleg[5] = 1'b1; pend[9] = 1'b1; pa[9] = 1;
        both("R3 not enabled", 32'h0);

        // R8: priority storage absent
        clear(); put(2, 1); put(5, 200); impl = 1'b0;
        both("R8 default order only", 32'h0005_0001);
        clear(); put(50, 7); put(11, 1); impl = 1'b0;
        both("R8 high group first", 32'h0032_0001);

        // R9: wide priorities
        clear(); put(20, 300); put(30, 256);
        step();
        chk("R9 wide clamp", out_b, 32'h001E_00FF);
        chk("R9 narrow view", out_a, 32'h0014_002C);
        clear(); put(40, 255); put(20, 300);
        step();
        chk("R9 wide 255 beats 300", out_b, 32'h0028_00FF);

        // R10: one register of latency
        clear(); put(7, 3);
        step();
        clear(); put(9, 4);
        pack();
        #1;
        chk("R10 holds until edge", out_a, 32'h0007_0003);
        step();
        chk("R10 updates after edge", out_a, 32'h0009_0004);

        // R3 R4 R5 R6 R7 R8 R9: random sweep against the reference
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            pend  = {rnd(), rnd()};
            enab  = {rnd(), rnd()} | {rnd(), rnd()};
            deleg = {rnd(), rnd()} & {rnd(), rnd()};
            if (n % 3 == 0) begin
                pend = pend & {rnd(), rnd()} & {rnd(), rnd()};
            end
            impl = (rnd() % 8) != 0;
            for (int c = 0; c < 64; c++) begin
                r = rnd();
                case (r % 4)
                    0: pa[c] = 0;
                    1: pa[c] = int'(r[9:8]) + 1;
                    2: pa[c] = int'(r[17:8]);
                    default: pa[c] = int'(r[15:8]);
                endcase
            end
            step();
            chk("R4/R5 random narrow", out_a, model(8));
            chk("R9 random wide",      out_b, model(10));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule